// File: doc/BRIEF.md
# Circular LIFO Stack with Relative Peek

This block is a small last-in-first-out store of 4-bit words, run from one clock. A 2-bit command picks one operation per rising edge. The operation can be idle, push a word, pop the top word, or peek at a word a given distance below the top. A peek leaves both the storage and the top pointer as they are.

The storage is a ring of five cells, tracked by a pointer to the next free slot. Past the fifth push, the ring wraps and the oldest word is overwritten. A pop on an empty stack also wraps and returns whatever that cell holds. Neither case raises a flag. The result comes from a registered output. Only pop and peek load that register, so it keeps its value through idle and push cycles.

Top module: `lifo_peek_stack`

## Requirements
- R1: A synchronous active-high `rst` clears every cell to 0, sets the pointer to the first slot and drives `dataOut` to 0. Peeks at every index after reset return 0.
- R2: Command code 0 (idle) changes neither the stored words nor the pointer, and `dataOut` keeps its value.
- R3: Command code 1 (push) writes `dataIn` into the slot above the current top, and that word becomes the new top. `dataOut` keeps its value during a push.
- R4: Command code 2 (pop) loads the top word into `dataOut` one edge later and lowers the pointer by one. The following pop returns the word below it.
- R5: Command code 3 (peek) loads into `dataOut` the word `peekIdx` positions below the top, where index 0 is the top itself. The pointer and the stored words are not changed.
- R6: `peekIdx` is 3 bits wide and is reduced modulo the depth (5) before addressing, so indices 5, 6 and 7 act as 0, 1 and 2.
- R7: A push into a full stack (five words held) overwrites the oldest word through pointer wraparound, with no error indication. Popping then cycles through the five newest words and wraps around.
- R8: A pop on an empty stack returns the word in the wrapped slot below the pointer, with no error indication. After reset, that word is 0.
- R9: Over an arbitrary mix of the four command codes, `dataOut` after each edge equals the result of a last-in-first-out ring model of depth 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Operation: 0 idle, 1 push, 2 pop, 3 peek |
| dataIn | input | 4 | Word to store on push |
| peekIdx | input | 3 | Distance below the top for a peek |
| dataOut | output | 4 | Registered result of the last pop or peek |

## Verification
Every result is due exactly one rising edge after its command. The command is applied before edge N, and `dataOut` shows the popped or peeked word after edge N. For idle and push, `dataOut` must still hold the earlier value after edge N. The driver applies one command per cycle on the falling edge and queues the value it expects for the next rising edge. The monitor compares each queued value shortly after that rising edge, so every comparison sits exactly one register stage behind its stimulus. Reset is checked directly once it has been released, and no expectation is queued while reset is asserted.

// File: rtl/lifo_stack_pkg.sv
package lifo_stack_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_POP  = 2'd2,
    CMD_PEEK = 2'd3
  } stackCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // store dataIn at wrAddr
    logic rdEn;   // load output register from rdAddr
  } ctrlStrb_t;

endpackage

// File: rtl/lifo_stack_ctrl.sv
module lifo_stack_ctrl
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int IDX_W = 3,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd,
  input  logic [IDX_W-1:0]  peekIdx,
  output ctrlStrb_t         strb,
  output logic [AW-1:0]     wrAddr,
  output logic [AW-1:0]     rdAddr,
  output logic [AW-1:0]     ptrOut
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  stackCmd_e      cmdDec;
  logic [AW-1:0]  ptr;
  logic [AW-1:0]  ptrNext;
  logic [AW-1:0]  topAddr;
  logic [AW-1:0]  idxMod;
  logic [AW-1:0]  offset;
  logic [AW:0]    sumWide;

  assign cmdDec = stackCmd_e'(cmd);

  // reduce the peek distance onto the ring
  assign idxMod = AW'(peekIdx % IDX_W'(DEPTH));

  // slot holding the current top word
  assign topAddr = (ptr == '0) ? LAST : ptr - AW'(1);

  always_comb begin
    offset = (cmdDec == CMD_PEEK) ? idxMod : '0;
    if (topAddr >= offset) begin
      sumWide = {1'b0, topAddr} - {1'b0, offset};
    end else begin
      sumWide = {1'b0, topAddr} + (AW+1)'(DEPTH) - {1'b0, offset};
    end
    rdAddr = sumWide[AW-1:0];
  end

  always_comb begin
    strb    = '0;
    ptrNext = ptr;
    unique case (cmdDec)
      CMD_PUSH: begin
        strb.wrEn = 1'b1;
        ptrNext   = (ptr == LAST) ? '0 : ptr + AW'(1);
      end
      CMD_POP: begin
        strb.rdEn = 1'b1;
        ptrNext   = topAddr;
      end
      CMD_PEEK: strb.rdEn = 1'b1;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptrNext;
  end

  assign wrAddr = ptr;
  assign ptrOut = ptr;

endmodule

// File: rtl/lifo_stack_dp.sv
module lifo_stack_dp
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] cells [DEPTH];
  logic [WIDTH-1:0] rdWord;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[gi] <= '0;
      end else if (strb.wrEn && (wrAddr == AW'(gi))) begin
        cells[gi] <= dataIn;
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdAddr == AW'(i)) rdWord = cells[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            dataOut <= '0;
    else if (strb.rdEn) dataOut <= rdWord;
  end

endmodule

// File: rtl/lifo_peek_stack.sv
module lifo_peek_stack
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int WIDTH = 4,
  parameter int IDX_W = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [IDX_W-1:0] peekIdx,
  output logic [WIDTH-1:0] dataOut
);

  ctrlStrb_t     strb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] topPtr;

  lifo_stack_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .peekIdx (peekIdx),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .ptrOut  (topPtr)
  );

  lifo_stack_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/lifo_peek_stack_chk.sv
module lifo_peek_stack_chk
  import lifo_stack_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int WIDTH = 4,
  parameter int IDX_W = 3,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cmd,
  input logic [WIDTH-1:0] dataIn,
  input logic [IDX_W-1:0] peekIdx,
  input logic [WIDTH-1:0] dataOut,
  input logic [AW-1:0]    topPtr
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (dataOut == '0));

  assert_idle_push_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_IDLE || cmd == CMD_PUSH) |=> $stable(dataOut));

  assert_push_then_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PUSH) |=> (cmd == CMD_POP) |=> (dataOut == $past(dataIn, 2)));

  assert_push_then_peek_top_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PUSH) |=> (cmd == CMD_PEEK && peekIdx == '0) |=> (dataOut == $past(dataIn, 2)));

  assert_peek_keeps_ptr_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PEEK || cmd == CMD_IDLE) |=> $stable(topPtr));

  assert_ptr_on_ring_R7: assert property (@(posedge clk) disable iff (rst)
    topPtr < AW'(DEPTH));

endmodule

bind lifo_peek_stack lifo_peek_stack_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W), .AW(AW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cmd     (cmd),
  .dataIn  (dataIn),
  .peekIdx (peekIdx),
  .dataOut (dataOut),
  .topPtr  (topPtr)
);

// File: tb/lifo_peek_stack_tb.sv
`timescale 1ns/1ps
module lifo_peek_stack_tb;

  localparam int DEPTH = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic [3:0] dataIn = 4'd0;
  logic [2:0] peekIdx = 3'd0;
  logic [3:0] dataOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  // reference ring model built from the requirements
  logic [3:0] mdl [DEPTH];
  int         mPtr;
  logic [3:0] mOut;

  always #5 clk = ~clk;

  lifo_peek_stack u_dut (
    .clk(clk), .rst(rst), .cmd(cmd), .dataIn(dataIn),
    .peekIdx(peekIdx), .dataOut(dataOut)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: dataOut=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares one edge after each command
  always @(posedge clk) begin
    #1;
    if (!rst && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(dataOut, it.val, it.tag);
    end
  end

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cmd = 2'd0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 4'd0;
    mPtr = 0;
    mOut = 4'd0;
    check(dataOut, 4'd0, "R1");
  endtask

  // driver: apply one command and queue its expected result
  task automatic step(input logic [1:0] c, input logic [3:0] d,
                      input logic [2:0] k, input string tag);
    expItem_t it;
    @(negedge clk);
    cmd = c;
    dataIn = d;
    peekIdx = k;
    case (c)
      2'd1: begin
        mdl[mPtr] = d;
        mPtr = (mPtr + 1) % DEPTH;
      end
      2'd2: begin
        mPtr = (mPtr + DEPTH - 1) % DEPTH;
        mOut = mdl[mPtr];
      end
      2'd3: mOut = mdl[(mPtr + 2*DEPTH - 1 - (int'(k) % DEPTH)) % DEPTH];
      default: ;
    endcase
    it.val = mOut;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  initial begin
    #(200000 * 10);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    if (!finished) begin
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    doReset();
    // R1: every cell is zero after reset
    for (int i = 0; i < DEPTH; i++) step(2'd3, 4'hF, 3'(i), "R1");
    // R8: pop on empty stack returns wrapped slot content (0)
    step(2'd2, 4'h0, 3'd0, "R8");
    step(2'd1, 4'hA, 3'd0, "R8");
    step(2'd3, 4'h0, 3'd0, "R8");

    doReset();
    // R3: pushes store words, output holds
    step(2'd1, 4'h3, 3'd0, "R3");
    step(2'd1, 4'h9, 3'd0, "R3");
    step(2'd1, 4'hC, 3'd0, "R3");
    // R5: peek distances from top
    step(2'd3, 4'h0, 3'd0, "R5");
    step(2'd3, 4'h0, 3'd1, "R5");
    step(2'd3, 4'h0, 3'd2, "R5");
    // R2: idle keeps output and contents
    step(2'd0, 4'h7, 3'd1, "R2");
    step(2'd0, 4'h5, 3'd0, "R2");
    step(2'd3, 4'h0, 3'd0, "R2");
    // R6: index reduced modulo depth
    step(2'd3, 4'h0, 3'd5, "R6");
    step(2'd3, 4'h0, 3'd6, "R6");
    step(2'd3, 4'h0, 3'd7, "R6");
    // R4: pops return top then the word below
    step(2'd2, 4'h0, 3'd0, "R4");
    step(2'd2, 4'h0, 3'd0, "R4");
    step(2'd1, 4'h7, 3'd0, "R4");
    step(2'd3, 4'h0, 3'd0, "R4");
    step(2'd3, 4'h0, 3'd1, "R4");

    doReset();
    // R7: six pushes overwrite the oldest word
    for (int i = 1; i <= 6; i++) step(2'd1, 4'(i), 3'd0, "R7");
    for (int i = 0; i < DEPTH; i++) step(2'd3, 4'h0, 3'(i), "R7");
    for (int i = 0; i < DEPTH + 1; i++) step(2'd2, 4'h0, 3'd0, "R7");

    // R1: reset in mid-run clears stored words
    step(2'd1, 4'hE, 3'd0, "R1");
    doReset();
    step(2'd3, 4'h0, 3'd0, "R1");
    step(2'd3, 4'h0, 3'd4, "R1");

    // R9: mixed command stream against the ring model
    lfsr = 8'h5B;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[1:0], lfsr[7:4], lfsr[4:2], "R9");
    end

    step(2'd0, 4'h0, 3'd0, "R9");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule